// File: doc/BRIEF.md
# Two-Dimensional Spread-Spectrum Despreader

This block recovers data symbols from a multicarrier code-division stream in which each symbol was spread across a run of adjacent sub-carriers and also across several consecutive OFDM symbols. It receives one channel-equalized sample per clock. Samples arrive in sub-carrier order, and the last sub-carrier of one OFDM symbol is followed by the first sub-carrier of the next. Each sample comes with a one-bit spreading chip. A single adder with a feedback register correlates each group of `2^f_log` neighbouring sub-carriers against the chips. Each partial sum is then parked in a word memory indexed by its sub-carrier group. That memory accumulates the partial sums over `2^t_log` OFDM symbols.

Once the last OFDM symbol of a time group has been received, the block issues one despread value per sub-carrier group, in ascending group order, each with a one-cycle valid strobe. The two spreading exponents are run-time inputs. A new pair takes effect only at an OFDM symbol boundary, and a change discards any accumulation already under way.

Top module: `sd2_despreader`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is 0 until a complete spread block has been received.
- R2: With `cfg_t_log` = 0, one result is produced per group of `2^cfg_f_log` consecutive samples. The result is the sum of the samples, where chip bit 0 means +1 and chip bit 1 means -1 (the sample is negated).
- R3: `out_data` is DATA_W+log2(SF_MAX)+1 bits, two's complement. Full-scale sums are exact: 16 terms of -2048 with chip 1 give +32768, and 16 terms of -2048 with chip 0 give -32768.
- R4: With `cfg_t_log` > 0, results appear only during the last OFDM symbol of each group of `2^cfg_t_log` symbols. There are NC/2^cfg_f_log results, in ascending group index. Each result is the sum over all symbols of the group of the chip-signed samples of that sub-carrier group.
- R5: `out_valid` rises at the second rising clock edge after the edge that samples the last chip of a finished block. It stays high for exactly one cycle per result.
- R6: A cycle with `in_valid` low advances no counter and changes no accumulation. Idle gaps inside a symbol leave every result unchanged.
- R7: The spreading exponents are sampled only with the first sample (sub-carrier 0) of each OFDM symbol. Values present with any other sample are ignored.
- R8: When the sampled exponents differ from those of the previous symbol, the time group restarts with that symbol. Partial sums from before the change never enter a result.
- R9: The first symbol of every time group overwrites its memory word, so no content from an earlier group reaches a later result.
- R10: After NC valid samples, the sub-carrier position wraps to 0 and the next OFDM symbol begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the sample and chip on this cycle |
| in_data | input | DATA_W | Equalized sample, two's complement |
| in_chip | input | 1 | Spreading chip, 0 = +1, 1 = -1 |
| cfg_f_log | input | 3 | log2 of the frequency spreading factor |
| cfg_t_log | input | 3 | log2 of the time spreading factor |
| out_valid | output | 1 | One-cycle strobe for each despread value |
| out_data | output | ACC_W | Despread value, two's complement |

## Verification
The bench builds the block with NC = 32, DATA_W = 12 and SF_MAX = 16. A short OFDM symbol lets a full sixteen-symbol time group finish within a few hundred cycles, so every split of the spreading factor between frequency and time can be covered, including both extremes. At these widths, sixteen full-scale terms land exactly on the +32768 and -32768 limits of the 17-bit result. With 32 sub-carriers, memory words from one configuration can also be revisited by a differently sized grouping right after a change.

// File: rtl/sd2_pkg.sv
package sd2_pkg;

   // run-time spreading exponents, each the log2 of a spreading factor
   typedef struct packed {
      logic [2:0] f_log;
      logic [2:0] t_log;
   } sd2_cfg_t;

   localparam int CFG_LOG_MAX = 7;

endpackage

// File: rtl/sd2_ctrl.sv
// Position tracking: sub-carrier index, symbol index within the time group,
// and the spreading exponents latched at each symbol boundary.
module sd2_ctrl
   import sd2_pkg::*;
#(
   parameter int NC     = 64,
   parameter int SF_MAX = 16,
   localparam int SC_W  = $clog2(NC),
   localparam int SYM_W = $clog2(SF_MAX)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  sd2_cfg_t        cfg_in,
   output sd2_cfg_t        cfg_act,
   output logic [SC_W-1:0] sc_idx,
   output logic [SC_W-1:0] grp_addr,
   output logic            chip_first,
   output logic            chip_last,
   output logic            sym_first,
   output logic            sym_last
);

   localparam logic [SC_W:0]  ONE_C   = (SC_W+1)'(1);
   localparam logic [SYM_W:0] ONE_S   = (SYM_W+1)'(1);
   localparam logic [SC_W-1:0] SC_TOP = SC_W'(NC - 1);

   logic [SC_W-1:0]  sc_q;
   logic [SYM_W-1:0] sym_q;
   sd2_cfg_t         cfg_q;

   logic             at_start;
   logic             sc_wrap;
   logic             cfg_chg;
   sd2_cfg_t         cfg_eff;
   logic [SYM_W-1:0] sym_eff;
   logic [SC_W:0]    chip_span;
   logic [SC_W-1:0]  chip_mask;
   logic [SC_W-1:0]  chip_pos;
   logic [SYM_W:0]   sym_span;
   logic [SYM_W-1:0] sym_top;
   logic [SYM_W-1:0] sym_next;

   always_comb begin
      at_start  = (sc_q == '0);
      sc_wrap   = (sc_q == SC_TOP);
      cfg_eff   = at_start ? cfg_in : cfg_q;
      cfg_chg   = at_start && (cfg_in != cfg_q);
      sym_eff   = cfg_chg ? '0 : sym_q;
      chip_span = ONE_C << cfg_eff.f_log;
      chip_mask = SC_W'(chip_span - ONE_C);
      chip_pos  = sc_q & chip_mask;
      sym_span  = ONE_S << cfg_eff.t_log;
      sym_top   = SYM_W'(sym_span - ONE_S);
      sym_next  = (sym_eff == sym_top) ? '0 : sym_eff + SYM_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q  <= '0;
         sym_q <= '0;
         cfg_q <= '0;
      end else if (in_valid) begin
         sc_q  <= sc_wrap ? '0 : sc_q + SC_W'(1);
         sym_q <= sc_wrap ? sym_next : sym_eff;
         if (at_start) begin
            cfg_q <= cfg_in;
         end
      end
   end

   assign cfg_act    = cfg_q;
   assign sc_idx     = sc_q;
   assign grp_addr   = sc_q >> cfg_eff.f_log;
   assign chip_first = (chip_pos == '0);
   assign chip_last  = (chip_pos == chip_mask);
   assign sym_first  = (sym_eff == '0);
   assign sym_last   = (sym_eff == sym_top);

endmodule

// File: rtl/sd2_freq_acc.sv
// Frequency-domain correlation: sign flip by chip, one adder, loopback register.
module sd2_freq_acc #(
   parameter int DATA_W = 12,
   parameter int ACC_W  = 17,
   parameter int AW     = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   input  logic                     in_chip,
   input  logic                     chip_first,
   input  logic                     chip_last,
   input  logic                     sym_first,
   input  logic                     sym_last,
   input  logic [AW-1:0]            grp_addr,
   output logic                     part_valid,
   output logic signed [ACC_W-1:0]  part_sum,
   output logic [AW-1:0]            part_addr,
   output logic                     part_first,
   output logic                     part_last
);

   logic signed [ACC_W-1:0] ext;
   logic signed [ACC_W-1:0] term;
   logic signed [ACC_W-1:0] base;
   logic signed [ACC_W-1:0] sum_now;
   logic signed [ACC_W-1:0] run_q;

   always_comb begin
      ext     = ACC_W'(in_data);
      term    = in_chip ? -ext : ext;
      base    = chip_first ? '0 : run_q;
      sum_now = base + term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= '0;
         part_valid <= 1'b0;
         part_sum   <= '0;
         part_addr  <= '0;
         part_first <= 1'b0;
         part_last  <= 1'b0;
      end else begin
         part_valid <= in_valid && chip_last;
         if (in_valid) begin
            run_q <= sum_now;
         end
         if (in_valid && chip_last) begin
            part_sum   <= sum_now;
            part_addr  <= grp_addr;
            part_first <= sym_first;
            part_last  <= sym_last;
         end
      end
   end

endmodule

// File: rtl/sd2_time_acc.sv
// Time-domain accumulation through an intermediate word memory, with bypass
// when the time group is a single symbol.
module sd2_time_acc #(
   parameter int NC    = 64,
   parameter int ACC_W = 17,
   localparam int AW   = $clog2(NC)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    part_valid,
   input  logic signed [ACC_W-1:0] part_sum,
   input  logic [AW-1:0]           part_addr,
   input  logic                    part_first,
   input  logic                    part_last,
   output logic                    out_valid,
   output logic signed [ACC_W-1:0] out_data
);

   logic signed [ACC_W-1:0] mem_q [NC];
   logic signed [ACC_W-1:0] rd_word;
   logic signed [ACC_W-1:0] acc_sum;
   logic                    wr_en;

   always_comb begin
      rd_word = mem_q[part_addr];
      acc_sum = part_first ? part_sum : rd_word + part_sum;
      wr_en   = part_valid && !part_last;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[part_addr] <= acc_sum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= part_valid && part_last;
         if (part_valid && part_last) begin
            out_data <= acc_sum;
         end
      end
   end

endmodule

// File: rtl/sd2_despreader.sv
module sd2_despreader
   import sd2_pkg::*;
#(
   parameter int NC     = 64,
   parameter int DATA_W = 12,
   parameter int SF_MAX = 16,
   parameter int ACC_W  = DATA_W + $clog2(SF_MAX) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_chip,
   input  logic [2:0]        cfg_f_log,
   input  logic [2:0]        cfg_t_log,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_data
);

   localparam int SC_W   = $clog2(NC);
   localparam int SF_LOG = $clog2(SF_MAX);

   // elaboration-time parameter checks
   if (SF_MAX < 2 || (1 << SF_LOG) != SF_MAX) begin : g_bad_sfmax
      $error("SF_MAX must be a power of two of at least 2");
   end
   if (SF_LOG > CFG_LOG_MAX) begin : g_bad_sflog
      $error("SF_MAX exceeds the range of the exponent inputs");
   end
   if (NC < SF_MAX || (NC % SF_MAX) != 0) begin : g_bad_nc
      $error("NC must be a nonzero multiple of SF_MAX");
   end
   if (ACC_W < DATA_W + SF_LOG + 1) begin : g_bad_accw
      $error("ACC_W too narrow for a full-scale sum");
   end

   sd2_cfg_t                cfg_in;
   sd2_cfg_t                cfg_act;
   logic [SC_W-1:0]         sc_idx;
   logic [SC_W-1:0]         grp_addr;
   logic                    chip_first;
   logic                    chip_last;
   logic                    sym_first;
   logic                    sym_last;
   logic                    part_valid;
   logic signed [ACC_W-1:0] part_sum;
   logic [SC_W-1:0]         part_addr;
   logic                    part_first;
   logic                    part_last;
   logic signed [ACC_W-1:0] res_data;

   assign cfg_in.f_log = cfg_f_log;
   assign cfg_in.t_log = cfg_t_log;

   sd2_ctrl #(
      .NC     (NC),
      .SF_MAX (SF_MAX)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .cfg_in     (cfg_in),
      .cfg_act    (cfg_act),
      .sc_idx     (sc_idx),
      .grp_addr   (grp_addr),
      .chip_first (chip_first),
      .chip_last  (chip_last),
      .sym_first  (sym_first),
      .sym_last   (sym_last)
   );

   sd2_freq_acc #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .AW     (SC_W)
   ) u_freq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    ($signed(in_data)),
      .in_chip    (in_chip),
      .chip_first (chip_first),
      .chip_last  (chip_last),
      .sym_first  (sym_first),
      .sym_last   (sym_last),
      .grp_addr   (grp_addr),
      .part_valid (part_valid),
      .part_sum   (part_sum),
      .part_addr  (part_addr),
      .part_first (part_first),
      .part_last  (part_last)
   );

   sd2_time_acc #(
      .NC    (NC),
      .ACC_W (ACC_W)
   ) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .part_valid (part_valid),
      .part_sum   (part_sum),
      .part_addr  (part_addr),
      .part_first (part_first),
      .part_last  (part_last),
      .out_valid  (out_valid),
      .out_data   (res_data)
   );

   assign out_data = res_data;

endmodule

// File: rtl/sd2_despreader_chk.sv
module sd2_despreader_chk
   import sd2_pkg::*;
#(
   parameter int NC     = 64,
   parameter int DATA_W = 12,
   parameter int SF_MAX = 16,
   parameter int ACC_W  = 17,
   localparam int SC_W  = $clog2(NC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [SC_W-1:0]  sc_idx,
   input sd2_cfg_t         cfg_act,
   input logic             part_valid,
   input logic             out_valid,
   input logic [ACC_W-1:0] out_data
);

   localparam logic signed [ACC_W-1:0] HI = ACC_W'(SF_MAX << (DATA_W - 1));
   localparam logic signed [ACC_W-1:0] LO = -HI;
   localparam logic [SC_W-1:0] SC_TOP = SC_W'(NC - 1);

   // R1: no result or partial straight out of reset
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !part_valid));

   // R3: result stays inside the full-scale range
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(out_data) <= HI && $signed(out_data) >= LO));

   // R5: a result follows a finished partial one cycle earlier
   p_out_after_part_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(part_valid));

   // R5: a result needs an accepted sample two cycles earlier
   p_out_after_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   // R6: idle cycles do not move the sub-carrier position
   p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(sc_idx));

   // R7: exponents change only with the first sample of a symbol
   p_cfg_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sc_idx != '0) |=> $stable(cfg_act));

   // R10: position wraps after the last sub-carrier
   p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sc_idx == SC_TOP) |=> (sc_idx == '0));

endmodule

bind sd2_despreader sd2_despreader_chk #(
   .NC     (NC),
   .DATA_W (DATA_W),
   .SF_MAX (SF_MAX),
   .ACC_W  (ACC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .sc_idx     (sc_idx),
   .cfg_act    (cfg_act),
   .part_valid (part_valid),
   .out_valid  (out_valid),
   .out_data   (out_data)
);

// File: tb/sd2_despreader_test.sv
`timescale 1ns/1ps
module sd2_despreader_test;

   localparam int NC    = 32;
   localparam int DW    = 12;
   localparam int SFM   = 16;
   localparam int AW    = DW + 4 + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_chip = 1'b0;
   logic [2:0]    cfg_f_log = '0;
   logic [2:0]    cfg_t_log = '0;
   logic          out_valid;
   logic [AW-1:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   int got_q[$];
   int exp_q[$];
   logic [31:0] seed = 32'h1234_5678;
   bit monitor_on = 1'b1;

   always #2.5 clk = ~clk;

   sd2_despreader #(.NC(NC), .DATA_W(DW), .SF_MAX(SFM)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_chip(in_chip), .cfg_f_log(cfg_f_log), .cfg_t_log(cfg_t_log),
      .out_valid(out_valid), .out_data(out_data)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && monitor_on) got_q.push_back(int'($signed(out_data)));
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic rnd(output int v);
      seed = seed * 32'd1664525 + 32'd1013904223;
      v = int'(seed[27:12]);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R1 idle after reset", int'(out_valid), 0);
      got_q.delete(); exp_q.delete();
   endtask

   // stream whole symbols; mode 0 random, mode 1 full scale
   task automatic stream(input int fl, input int tl, input int nsym, input int mode,
                         input bit wiggle, input bit gaps, input bit rst, input string req);
      int sff, sft, r, d, c, f, n, term;
      int acc[NC];
      sff = 1 << fl; sft = 1 << tl;
      if (rst) do_reset();
      for (int m = 0; m < nsym; m++) begin
         n = m % sft;
         for (int i = 0; i < NC; i++) begin
            if (gaps) begin
               rnd(r);
               if (r % 3 == 0) begin
                  @(negedge clk); in_valid = 1'b0;
                  cfg_f_log = 3'(fl ^ 2); cfg_t_log = 3'(tl ^ 1);
               end
            end
            if (mode == 1) begin
               d = -2048; c = ((i / sff) % 2 == 0) ? 1 : 0;
            end else begin
               rnd(r); d = (r % 4096) - 2048; rnd(r); c = r % 2;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = DW'(d); in_chip = c[0];
            if (wiggle && i != 0) begin
               cfg_f_log = 3'(fl ^ 1); cfg_t_log = 3'(tl ^ 2);
            end else begin
               cfg_f_log = 3'(fl); cfg_t_log = 3'(tl);
            end
            f = i / sff;
            term = c ? -d : d;
            if (n == 0 && i % sff == 0) acc[f] = term;
            else acc[f] = acc[f] + term;
            if (n == sft - 1 && i % sff == sff - 1) exp_q.push_back(acc[f]);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(got_q.size() == exp_q.size(), {req, " result count"}, got_q.size(), exp_q.size());
      for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
         check(got_q[k] == exp_q[k], req, got_q[k], exp_q[k]);
      got_q.delete(); exp_q.delete();
   endtask

   task automatic t_reset();
      do_reset();
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0, "R1 no strobe while idle", int'(out_valid), 0);
   endtask

   // R5: two edges from last chip to strobe, one-cycle pulse
   task automatic t_latency();
      do_reset();
      monitor_on = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; cfg_f_log = 3'd1; cfg_t_log = 3'd0; in_data = DW'(100); in_chip = 1'b0;
      @(negedge clk);
      in_data = DW'(-30); in_chip = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b0, "R5 not yet after one edge", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b1, "R5 strobe after two edges", int'(out_valid), 1);
      check(int'($signed(out_data)) == 130, "R5 R2 value", int'($signed(out_data)), 130);
      @(negedge clk);
      check(out_valid == 1'b0, "R5 single-cycle pulse", int'(out_valid), 0);
      monitor_on = 1'b1;
   endtask

   task automatic t_freq();
      stream(4, 0, 2, 0, 0, 0, 1, "R2 sff16");
      stream(1, 0, 2, 0, 0, 0, 1, "R2 sff2");
      stream(3, 0, 1, 0, 0, 0, 1, "R2 sff8");
   endtask

   task automatic t_time();
      stream(0, 4, 16, 0, 0, 0, 1, "R4 sft16");
      stream(2, 2, 8, 0, 0, 0, 1, "R4 4x4");
      stream(1, 3, 8, 0, 0, 0, 1, "R4 2x8");
   endtask

   task automatic t_full();
      stream(4, 0, 1, 1, 0, 0, 1, "R3 full 16x1");
      stream(2, 2, 4, 1, 0, 0, 1, "R3 full 4x4");
      stream(0, 4, 16, 1, 0, 0, 1, "R3 full 1x16");
   endtask

   task automatic t_gaps();
      stream(2, 1, 4, 0, 0, 1, 1, "R6 idle gaps");
   endtask

   task automatic t_cfg_mid();
      stream(1, 2, 8, 0, 1, 0, 1, "R7 mid-symbol cfg ignored");
   endtask

   // R8 and R9: partial group discarded, memory words reused across configs
   task automatic t_switch();
      stream(0, 3, 3, 0, 0, 0, 1, "R8 partial group silent");
      stream(2, 1, 4, 0, 0, 0, 0, "R8 after change");
      stream(3, 0, 2, 0, 0, 0, 0, "R8 bypass after change");
      stream(0, 1, 2, 0, 0, 0, 0, "R9 overwrite first symbol");
      stream(0, 1, 4, 0, 0, 0, 0, "R9 repeated groups");
   endtask

   task automatic t_wrap();
      stream(1, 1, 6, 0, 0, 0, 1, "R10 symbol wrap");
   endtask

   initial begin
      t_reset();
      t_latency();
      t_freq();
      t_time();
      t_full();
      t_gaps();
      t_cfg_mid();
      t_switch();
      t_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule